// File: doc/BRIEF.md
# Two-Level Cache with Exclusive Victim Store

This block is a small first-level data cache backed by a fully associative victim store. The two levels never hold the same address at once. A line that leaves the first level is parked in the victim store instead of being dropped. A line that is found in the victim store is moved back into the first level, and its victim entry is released. Lines fetched from memory go only into the first level.

Each cache line holds a single data word, and addresses are word addresses. The core issues one read or write at a time. It sees a one-cycle response pulse that says whether the access hit the first level, hit the victim store, or went to memory. On the memory side there is a read request that is held until the fill data arrives, and a single-cycle writeback pulse for dirty lines that are pushed out of the victim store.

Top module: `xvc_cache`

## Requirements
- R1: After reset both levels are empty, `req_ready` is 1 and `rsp_valid`, `mem_rd_req` and `mem_wb_valid` are 0, so the first access to any address is a miss.
- R2: A read that hits the first level raises `rsp_valid` with `rsp_l1_hit`=1 in the cycle right after acceptance, returns the stored word, and starts no memory read. For any write, `rsp_rdata` carries the written word.
- R3: The first level is 2-way set-associative and is indexed by the low log2(L1_SETS) address bits. When a set is full, the way used least recently is the one replaced.
- R4: A line evicted from the first level goes into the victim store. A later read of that line reports `rsp_vs_hit`=1 with the correct data and no memory read.
- R5: When an access misses both levels, one memory read is issued. The returned line is placed only in the first level, and the response has both hit flags at 0.
- R6: A victim-store hit moves the line into the first level and invalidates its victim entry. The next access to it is a first-level hit, and no address is ever found in both levels.
- R7: A victim-store hit responds exactly EXTRA_LAT cycles later than a first-level hit would.
- R8: If a victim-store hit has to evict a first-level line, that line takes over the freed victim entry and can later be read back as a victim-store hit.
- R9: When the victim store is full and must take a new line, it discards the entry that was inserted least recently. Lines that were inserted later remain.
- R10: A dirty discarded line is written back to memory with one `mem_wb_valid` pulse carrying its address and data, in the same cycle as the fill response that caused the discard. A clean discard produces no writeback.
- R11: A write that hits the first level updates the word in place and marks the line dirty. A following read returns the new word.
- R12: A write that misses fills the line from memory, merges the written word into it and marks it dirty. The dirty state survives a move to the victim store and back.
- R13: `mem_rd_req` and `mem_rd_addr` stay stable from the request until the cycle in which `mem_rd_valid` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Block is idle and accepts a request |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_l1_hit | output | 1 | Response came from the first level |
| rsp_vs_hit | output | 1 | Response came from the victim store |
| rsp_rdata | output | DATA_W | Read data, or the written word for writes |
| mem_rd_req | output | 1 | Memory line read request, held until served |
| mem_rd_addr | output | ADDR_W | Address of the line to read |
| mem_rd_valid | input | 1 | Memory fill data present |
| mem_rd_data | input | DATA_W | Memory fill data |
| mem_wb_valid | output | 1 | One-cycle writeback pulse |
| mem_wb_addr | output | ADDR_W | Writeback address |
| mem_wb_data | output | DATA_W | Writeback data |

## Verification
The hardest case to reach from the ports is a discard out of a full victim store, and especially the discard of a dirty line. Reaching it takes more first-level evictions than the store has entries. Those evictions must be stacked on top of lines whose insertion order the bench already knows. The stimulus first runs a table of swaps and writes that leaves one clean line and one dirty line as the oldest entries. It then streams a run of misses through a single set until the store overflows twice. The bench checks that the first overflow is silent and that the second one writes back the dirty word. Re-reading the discarded addresses then proves that they came back from memory.

// File: rtl/xvc_pkg.sv
package xvc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_VWAIT = 2'd1,
    ST_FILL  = 2'd2
  } xvc_state_e;

  // Replacement choice inside a 2-way set: an empty way first, else the LRU way.
  function automatic logic pick_way(input logic [1:0] vld, input logic lru_way);
    if (!vld[0])      return 1'b0;
    else if (!vld[1]) return 1'b1;
    else              return lru_way;
  endfunction
endpackage

// File: rtl/xvc_l1.sv
module xvc_l1 #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int SETS   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] lk_addr,
  output logic              lk_hit,
  output logic              lk_way,
  output logic [DATA_W-1:0] lk_data,
  output logic              vic_way,
  output logic              vic_valid,
  output logic [ADDR_W-1:0] vic_addr,
  output logic [DATA_W-1:0] vic_data,
  output logic              vic_dirty,
  input  logic              touch_en,
  input  logic              upd_en,
  input  logic              upd_way,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              upd_dirty
);
  import xvc_pkg::*;
  localparam int IDX_W = $clog2(SETS);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [1:0]        vld_q [SETS];
  logic [1:0]        dty_q [SETS];
  logic              lru_q [SETS];   // way that is least recently used
  logic [TAG_W-1:0]  tag_q [SETS][2];
  logic [DATA_W-1:0] dat_q [SETS][2];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tag;
  logic [1:0]       way_hit;
  logic             acc_way;

  assign idx = lk_addr[IDX_W-1:0];
  assign tag = lk_addr[ADDR_W-1:IDX_W];

  for (genvar gw = 0; gw < 2; gw++) begin : g_cmp
    assign way_hit[gw] = vld_q[idx][gw] && (tag_q[idx][gw] == tag);
  end

  assign lk_hit    = |way_hit;
  assign lk_way    = way_hit[1];
  assign lk_data   = dat_q[idx][lk_way];
  assign vic_way   = pick_way(vld_q[idx], lru_q[idx]);
  assign vic_valid = vld_q[idx][vic_way];
  assign vic_addr  = {tag_q[idx][vic_way], idx};
  assign vic_data  = dat_q[idx][vic_way];
  assign vic_dirty = dty_q[idx][vic_way];
  assign acc_way   = upd_en ? upd_way : lk_way;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) begin
        vld_q[s] <= '0;
        dty_q[s] <= '0;
        lru_q[s] <= 1'b0;
      end
    end else begin
      if (upd_en) begin
        vld_q[idx][upd_way] <= 1'b1;
        dty_q[idx][upd_way] <= upd_dirty;
      end
      if (upd_en || touch_en) lru_q[idx] <= ~acc_way;
    end
  end

  always_ff @(posedge clk) begin
    if (upd_en) begin
      tag_q[idx][upd_way] <= tag;
      dat_q[idx][upd_way] <= upd_data;
    end
  end
endmodule

// File: rtl/xvc_vstore.sv
module xvc_vstore #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 32,
  parameter int WAYS   = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    lk_addr,
  output logic                 lk_hit,
  output logic [$clog2(WAYS)-1:0] lk_way,
  output logic [DATA_W-1:0]    lk_data,
  output logic                 lk_dirty,
  output logic [$clog2(WAYS)-1:0] al_way,
  output logic                 al_valid,
  output logic [ADDR_W-1:0]    al_addr,
  output logic [DATA_W-1:0]    al_data,
  output logic                 al_dirty,
  input  logic                 put_en,
  input  logic [$clog2(WAYS)-1:0] put_way,
  input  logic [ADDR_W-1:0]    put_addr,
  input  logic [DATA_W-1:0]    put_data,
  input  logic                 put_dirty,
  input  logic                 free_en,
  input  logic [$clog2(WAYS)-1:0] free_way
);
  localparam int W_W = $clog2(WAYS);
  localparam logic [W_W-1:0] AGE_MAX = W_W'(WAYS - 1);

  logic [WAYS-1:0]   vld_w;
  logic [WAYS-1:0]   dty_w;
  logic [WAYS-1:0]   hit_vec;
  logic [WAYS-1:0]   old_vec;
  logic [ADDR_W-1:0] adr_w [WAYS];
  logic [DATA_W-1:0] dat_w [WAYS];
  logic [W_W-1:0]    age_w [WAYS];

  // Lowest set bit position of a vector.
  function automatic logic [W_W-1:0] first_one(input logic [WAYS-1:0] v);
    logic [W_W-1:0] r;
    r = '0;
    for (int i = WAYS - 1; i >= 0; i--) if (v[i]) r = W_W'(i);
    return r;
  endfunction

  for (genvar g = 0; g < WAYS; g++) begin : g_ent
    logic              vld_q;
    logic              dty_q;
    logic [ADDR_W-1:0] adr_q;
    logic [DATA_W-1:0] dat_q;
    logic [W_W-1:0]    age_q;

    // Ages form a permutation: 0 = newest, WAYS-1 = oldest.
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        dty_q <= 1'b0;
        age_q <= W_W'(g);
      end else if (put_en) begin
        if (put_way == W_W'(g)) begin
          vld_q <= 1'b1;
          dty_q <= put_dirty;
          age_q <= '0;
        end else if (age_q < age_w[put_way]) begin
          age_q <= age_q + 1'b1;
        end
      end else if (free_en) begin
        if (free_way == W_W'(g)) begin
          vld_q <= 1'b0;
          age_q <= AGE_MAX;
        end else if (age_q > age_w[free_way]) begin
          age_q <= age_q - 1'b1;
        end
      end
    end

    always_ff @(posedge clk) begin
      if (put_en && (put_way == W_W'(g))) begin
        adr_q <= put_addr;
        dat_q <= put_data;
      end
    end

    assign vld_w[g]   = vld_q;
    assign dty_w[g]   = dty_q;
    assign adr_w[g]   = adr_q;
    assign dat_w[g]   = dat_q;
    assign age_w[g]   = age_q;
    assign hit_vec[g] = vld_q && (adr_q == lk_addr);
    assign old_vec[g] = (age_q == AGE_MAX);
  end

  assign lk_hit   = |hit_vec;
  assign lk_way   = first_one(hit_vec);
  assign lk_data  = dat_w[lk_way];
  assign lk_dirty = dty_w[lk_way];
  assign al_way   = (&vld_w) ? first_one(old_vec) : first_one(~vld_w);
  assign al_valid = vld_w[al_way];
  assign al_addr  = adr_w[al_way];
  assign al_data  = dat_w[al_way];
  assign al_dirty = dty_w[al_way];
endmodule

// File: rtl/xvc_cache.sv
module xvc_cache #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 32,
  parameter int L1_SETS   = 4,
  parameter int VS_WAYS   = 16,
  parameter int EXTRA_LAT = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_we,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic              rsp_l1_hit,
  output logic              rsp_vs_hit,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              mem_rd_req,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [DATA_W-1:0] mem_rd_data,
  output logic              mem_wb_valid,
  output logic [ADDR_W-1:0] mem_wb_addr,
  output logic [DATA_W-1:0] mem_wb_data
);
  import xvc_pkg::*;
  localparam int VW_W  = $clog2(VS_WAYS);
  localparam int CNT_W = $clog2(EXTRA_LAT + 1);

  xvc_state_e        state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              cur_we;
  logic [ADDR_W-1:0] cur_addr;
  logic [DATA_W-1:0] cur_wdata;
  logic [ADDR_W-1:0] lk_addr;

  // first level
  logic              l1_lk_hit, l1_lk_way, l1_vic_way, l1_vic_valid, l1_vic_dirty;
  logic [DATA_W-1:0] l1_lk_data, l1_vic_data;
  logic [ADDR_W-1:0] l1_vic_addr;
  logic              l1_touch, l1_upd, l1_upd_way, l1_upd_dirty;
  logic [DATA_W-1:0] l1_upd_data;
  // victim store
  logic              vs_lk_hit, vs_lk_dirty, vs_al_valid, vs_al_dirty;
  logic [VW_W-1:0]   vs_lk_way, vs_al_way, vs_put_way;
  logic [DATA_W-1:0] vs_lk_data, vs_al_data;
  logic [ADDR_W-1:0] vs_al_addr;
  logic              vs_put, vs_free;

  // named events
  logic evt_accept, evt_l1_hit, evt_vs_hit, evt_miss, evt_vs_swap, evt_fill_done, evt_discard_wb;

  assign req_ready      = (state_q == ST_IDLE);
  assign lk_addr        = req_ready ? req_addr : cur_addr;
  assign evt_accept     = req_valid && req_ready;
  assign evt_l1_hit     = evt_accept && l1_lk_hit;
  assign evt_vs_hit     = evt_accept && !l1_lk_hit && vs_lk_hit;
  assign evt_miss       = evt_accept && !l1_lk_hit && !vs_lk_hit;
  assign evt_vs_swap    = (state_q == ST_VWAIT) && (cnt_q == CNT_W'(1));
  assign evt_fill_done  = (state_q == ST_FILL) && mem_rd_valid;
  assign evt_discard_wb = evt_fill_done && l1_vic_valid && vs_al_valid && vs_al_dirty;

  xvc_l1 #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(L1_SETS)) l1_i (
    .clk, .rst_n, .lk_addr,
    .lk_hit(l1_lk_hit), .lk_way(l1_lk_way), .lk_data(l1_lk_data),
    .vic_way(l1_vic_way), .vic_valid(l1_vic_valid), .vic_addr(l1_vic_addr),
    .vic_data(l1_vic_data), .vic_dirty(l1_vic_dirty),
    .touch_en(l1_touch), .upd_en(l1_upd), .upd_way(l1_upd_way),
    .upd_data(l1_upd_data), .upd_dirty(l1_upd_dirty)
  );

  xvc_vstore #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WAYS(VS_WAYS)) vs_i (
    .clk, .rst_n, .lk_addr,
    .lk_hit(vs_lk_hit), .lk_way(vs_lk_way), .lk_data(vs_lk_data), .lk_dirty(vs_lk_dirty),
    .al_way(vs_al_way), .al_valid(vs_al_valid), .al_addr(vs_al_addr),
    .al_data(vs_al_data), .al_dirty(vs_al_dirty),
    .put_en(vs_put), .put_way(vs_put_way), .put_addr(l1_vic_addr),
    .put_data(l1_vic_data), .put_dirty(l1_vic_dirty),
    .free_en(vs_free), .free_way(vs_lk_way)
  );

  always_comb begin
    l1_touch     = 1'b0;
    l1_upd       = 1'b0;
    l1_upd_way   = l1_lk_way;
    l1_upd_data  = req_wdata;
    l1_upd_dirty = 1'b0;
    vs_put       = 1'b0;
    vs_put_way   = vs_al_way;
    vs_free      = 1'b0;
    if (evt_l1_hit) begin
      if (req_we) begin
        l1_upd       = 1'b1;
        l1_upd_dirty = 1'b1;
      end else begin
        l1_touch = 1'b1;
      end
    end else if (evt_vs_swap) begin
      l1_upd       = 1'b1;
      l1_upd_way   = l1_vic_way;
      l1_upd_data  = cur_we ? cur_wdata : vs_lk_data;
      l1_upd_dirty = vs_lk_dirty || cur_we;
      if (l1_vic_valid) begin
        vs_put     = 1'b1;
        vs_put_way = vs_lk_way;
      end else begin
        vs_free = 1'b1;
      end
    end else if (evt_fill_done) begin
      l1_upd       = 1'b1;
      l1_upd_way   = l1_vic_way;
      l1_upd_data  = cur_we ? cur_wdata : mem_rd_data;
      l1_upd_dirty = cur_we;
      vs_put       = l1_vic_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q      <= ST_IDLE;
      cnt_q        <= '0;
      cur_we       <= 1'b0;
      cur_addr     <= '0;
      cur_wdata    <= '0;
      rsp_valid    <= 1'b0;
      rsp_l1_hit   <= 1'b0;
      rsp_vs_hit   <= 1'b0;
      rsp_rdata    <= '0;
      mem_rd_req   <= 1'b0;
      mem_rd_addr  <= '0;
      mem_wb_valid <= 1'b0;
      mem_wb_addr  <= '0;
      mem_wb_data  <= '0;
    end else begin
      rsp_valid    <= 1'b0;
      rsp_l1_hit   <= 1'b0;
      rsp_vs_hit   <= 1'b0;
      mem_wb_valid <= 1'b0;
      if (evt_accept) begin
        cur_we    <= req_we;
        cur_addr  <= req_addr;
        cur_wdata <= req_wdata;
      end
      unique case (state_q)
        ST_IDLE: begin
          if (evt_l1_hit) begin
            rsp_valid  <= 1'b1;
            rsp_l1_hit <= 1'b1;
            rsp_rdata  <= req_we ? req_wdata : l1_lk_data;
          end else if (evt_vs_hit) begin
            state_q <= ST_VWAIT;
            cnt_q   <= CNT_W'(EXTRA_LAT);
          end else if (evt_miss) begin
            state_q     <= ST_FILL;
            mem_rd_req  <= 1'b1;
            mem_rd_addr <= req_addr;
          end
        end
        ST_VWAIT: begin
          if (evt_vs_swap) begin
            state_q    <= ST_IDLE;
            rsp_valid  <= 1'b1;
            rsp_vs_hit <= 1'b1;
            rsp_rdata  <= l1_upd_data;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        ST_FILL: begin
          if (evt_fill_done) begin
            state_q    <= ST_IDLE;
            mem_rd_req <= 1'b0;
            rsp_valid  <= 1'b1;
            rsp_rdata  <= l1_upd_data;
            if (evt_discard_wb) begin
              mem_wb_valid <= 1'b1;
              mem_wb_addr  <= vs_al_addr;
              mem_wb_data  <= vs_al_data;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/xvc_cache_chk.sv
module xvc_cache_chk #(
  parameter int ADDR_W    = 10,
  parameter int EXTRA_LAT = 9
) (
  input logic              clk,
  input logic              rst_n,
  input logic              evt_accept,
  input logic              rsp_valid,
  input logic              rsp_l1_hit,
  input logic              rsp_vs_hit,
  input logic              mem_rd_req,
  input logic [ADDR_W-1:0] mem_rd_addr,
  input logic              mem_rd_valid,
  input logic              mem_wb_valid,
  input logic              l1_lk_hit,
  input logic              vs_lk_hit
);
  logic [15:0] since_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                since_q <= '0;
    else if (evt_accept)       since_q <= '0;
    else if (since_q != '1)    since_q <= since_q + 1'b1;
  end

  AST_LEVELS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(l1_lk_hit && vs_lk_hit)); // R6
  AST_RSP_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $onehot0({rsp_l1_hit, rsp_vs_hit})); // R2
  AST_L1_HIT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_l1_hit) |-> (since_q == 16'd0)); // R2
  AST_VS_HIT_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_vs_hit) |-> (since_q == 16'(EXTRA_LAT))); // R7
  AST_MEM_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd_req && !mem_rd_valid) |=> (mem_rd_req && $stable(mem_rd_addr))); // R13
  AST_WB_WITH_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wb_valid |-> (rsp_valid && !rsp_l1_hit && !rsp_vs_hit)); // R10
endmodule

bind xvc_cache xvc_cache_chk #(.ADDR_W(ADDR_W), .EXTRA_LAT(EXTRA_LAT)) chk_i (
  .clk(clk), .rst_n(rst_n), .evt_accept(evt_accept),
  .rsp_valid(rsp_valid), .rsp_l1_hit(rsp_l1_hit), .rsp_vs_hit(rsp_vs_hit),
  .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
  .mem_wb_valid(mem_wb_valid), .l1_lk_hit(l1_lk_hit), .vs_lk_hit(vs_lk_hit)
);

// File: tb/xvc_cache_tb.sv
module xvc_cache_tb_top;
  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam int LAT    = 9;
  localparam int MEMSZ  = 1 << ADDR_W;
  localparam logic [1:0] K_MISS = 2'd0, K_L1 = 2'd1, K_VS = 2'd2;

  typedef struct packed {
    logic              we;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] wdata;
    logic [1:0]        kind;
  } vec_t;

  // A=0x000 B=0x004 C=0x008 D=0x00C share set 0; E=0x001 is in set 1
  localparam vec_t VEC [16] = '{
    '{1'b0, 10'h000, 32'h0,         K_MISS}, // R1 R5
    '{1'b0, 10'h000, 32'h0,         K_L1},   // R2
    '{1'b0, 10'h004, 32'h0,         K_MISS}, // R5
    '{1'b0, 10'h000, 32'h0,         K_L1},   // R3 A becomes MRU
    '{1'b0, 10'h008, 32'h0,         K_MISS}, // R3 B evicted
    '{1'b0, 10'h000, 32'h0,         K_L1},   // R3 A kept
    '{1'b0, 10'h004, 32'h0,         K_VS},   // R4 R7
    '{1'b0, 10'h008, 32'h0,         K_VS},   // R8 C displaced earlier
    '{1'b0, 10'h004, 32'h0,         K_L1},   // R6 migrated
    '{1'b1, 10'h008, 32'hDEAD0001,  K_L1},   // R11
    '{1'b0, 10'h008, 32'h0,         K_L1},   // R11
    '{1'b1, 10'h00C, 32'hBEEF0002,  K_MISS}, // R12
    '{1'b0, 10'h00C, 32'h0,         K_L1},   // R12
    '{1'b0, 10'h001, 32'h0,         K_MISS}, // R5
    '{1'b0, 10'h000, 32'h0,         K_VS},   // R8
    '{1'b0, 10'h008, 32'h0,         K_VS}    // R12 dirty kept
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0, req_we = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic              req_ready, rsp_valid, rsp_l1_hit, rsp_vs_hit;
  logic [DATA_W-1:0] rsp_rdata;
  logic              mem_rd_req, mem_wb_valid;
  logic [ADDR_W-1:0] mem_rd_addr, mem_wb_addr;
  logic              mem_rd_valid = 1'b0;
  logic [DATA_W-1:0] mem_rd_data = '0, mem_wb_data;

  logic [DATA_W-1:0] mem_model [MEMSZ];
  logic [DATA_W-1:0] shadow    [MEMSZ];
  int checks = 0, errors = 0, mem_reads = 0, wb_count = 0;
  logic [ADDR_W-1:0] last_wb_addr = '0;
  logic [DATA_W-1:0] last_wb_data = '0;

  always #10 clk = ~clk;

  xvc_cache dut_i (
    .clk, .rst_n, .req_valid, .req_we, .req_addr, .req_wdata, .req_ready,
    .rsp_valid, .rsp_l1_hit, .rsp_vs_hit, .rsp_rdata,
    .mem_rd_req, .mem_rd_addr, .mem_rd_valid, .mem_rd_data,
    .mem_wb_valid, .mem_wb_addr, .mem_wb_data
  );

  function automatic logic [DATA_W-1:0] memf(input int a);
    return 32'h5A000000 + 32'(a) * 32'h00010003;
  endfunction

  function automatic string vtag(input int i);
    case (i)
      0: return "R1";  1: return "R2";  2, 13: return "R5";
      3, 4, 5: return "R3";  6: return "R4"; 7, 14: return "R8";
      8: return "R6";  9, 10: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_req(input logic we, input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] wd,
                        output logic [1:0] kind, output logic [DATA_W-1:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid) begin
      @(negedge clk);
      lat++;
    end
    kind = rsp_l1_hit ? K_L1 : (rsp_vs_hit ? K_VS : K_MISS);
    rd = rsp_rdata;
    if (we) shadow[a] = wd;
  endtask

  // memory model: answers a read on the third cycle, absorbs writebacks
  initial begin : mem_resp
    int wait_n;
    logic [ADDR_W-1:0] first_addr;
    wait_n = 0;
    first_addr = '0;
    forever begin
      @(negedge clk);
      if (mem_wb_valid) begin
        mem_model[mem_wb_addr] = mem_wb_data;
        last_wb_addr = mem_wb_addr;
        last_wb_data = mem_wb_data;
        wb_count++;
      end
      if (mem_rd_valid) begin
        mem_rd_valid = 1'b0;
      end else if (mem_rd_req) begin
        if (wait_n == 0) first_addr = mem_rd_addr;
        if (wait_n == 2) begin
          check(mem_rd_addr == first_addr, "R13 address held", 32'(mem_rd_addr), 32'(first_addr));
          mem_rd_valid = 1'b1;
          mem_rd_data  = mem_model[mem_rd_addr];
          mem_reads++;
          wait_n = 0;
        end else begin
          wait_n++;
        end
      end
    end
  end

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    logic [1:0]        k;
    logic [DATA_W-1:0] d;
    int                lat, r0, w0;
    for (int i = 0; i < MEMSZ; i++) begin
      mem_model[i] = memf(i);
      shadow[i]    = memf(i);
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1 ready", 32'(req_ready), 1);
    check(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    check(mem_rd_req == 1'b0 && mem_wb_valid == 1'b0, "R1 memory idle",
          32'({mem_rd_req, mem_wb_valid}), 0);
    rst_n = 1'b1;

    for (int i = 0; i < 16; i++) begin
      r0 = mem_reads;
      do_req(VEC[i].we, VEC[i].addr, VEC[i].wdata, k, d, lat);
      check(k == VEC[i].kind, {vtag(i), " kind"}, 32'(k), 32'(VEC[i].kind));
      check(d == shadow[VEC[i].addr], {vtag(i), " data"}, d, shadow[VEC[i].addr]);
      check(mem_reads - r0 == (VEC[i].kind == K_MISS ? 1 : 0), {vtag(i), " memory reads"},
            32'(mem_reads - r0), 32'(VEC[i].kind == K_MISS));
      if (VEC[i].kind == K_VS) check(lat == LAT, "R7 victim latency", 32'(lat), LAT);
      if (VEC[i].kind == K_L1) check(lat == 0, "R2 hit latency", 32'(lat), 0);
    end

    // R9 R10: overflow the victim store through set 2 (B clean, D dirty are oldest)
    w0 = wb_count;
    for (int j = 0; j < 18; j++) begin
      do_req(1'b0, ADDR_W'(4 * j + 2), '0, k, d, lat);
      check(k == K_MISS, "R9 stream fill", 32'(k), 32'(K_MISS));
      @(negedge clk);
      if (j == 16) check(wb_count == w0, "R10 clean discard silent", 32'(wb_count), 32'(w0));
      if (j == 17) begin
        check(wb_count == w0 + 1, "R10 dirty discard writes back", 32'(wb_count), 32'(w0 + 1));
        check(last_wb_addr == 10'h00C, "R10 writeback address", 32'(last_wb_addr), 32'h00C);
        check(last_wb_data == 32'hBEEF0002, "R10 writeback data", last_wb_data, 32'hBEEF0002);
      end
    end
    do_req(1'b0, 10'h006, '0, k, d, lat);
    check(k == K_VS, "R9 newer entry survives", 32'(k), 32'(K_VS));
    check(d == shadow[10'h006], "R9 survivor data", d, shadow[10'h006]);
    do_req(1'b0, 10'h004, '0, k, d, lat);
    check(k == K_MISS, "R9 oldest discarded", 32'(k), 32'(K_MISS));
    do_req(1'b0, 10'h00C, '0, k, d, lat);
    check(k == K_MISS, "R10 discarded dirty refetched", 32'(k), 32'(K_MISS));
    check(d == 32'hBEEF0002, "R10 memory holds written word", d, 32'hBEEF0002);

    // R1: reset in mid-run empties both levels
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    check(req_ready == 1'b1 && rsp_valid == 1'b0, "R1 reset again",
          32'({req_ready, rsp_valid}), 32'h2);
    rst_n = 1'b1;
    for (int i = 0; i < MEMSZ; i++) shadow[i] = mem_model[i];
    do_req(1'b0, 10'h00C, '0, k, d, lat);
    check(k == K_MISS, "R1 empty after reset", 32'(k), 32'(K_MISS));
    do_req(1'b0, 10'h002, '0, k, d, lat);
    check(k == K_MISS, "R1 victim store empty after reset", 32'(k), 32'(K_MISS));
    finish_run();
  end
endmodule